// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional ports, A and B. Each direction has a capture register with its own rising-edge clock. The A-to-B register samples the A port. The B-to-A register samples the B port. An active-low output enable and a direction input decide which port the block drives, if any. A per-direction select chooses what the driven port shows: the live value of the opposite port, or the value held in that direction's register.

Each physical port is split into three vectors: an input, a data output and a full-width output enable. This keeps the block synthesizable, and the pad ring or an external resolver recombines the three into a real bus. Registers capture on every rising edge of their clock whatever the enable and direction settings are. A port the block is not driving therefore still works as an input that can be stored. The block has no streaming handshake. Its pins are plain control and data levels.

Top module: `regxcvr_top`

## Requirements
- R1: An active-low asynchronous reset clears both capture registers to zero. After reset, a driven port with its select high shows 8'h00.
- R2: The A-to-B register loads the A port input on each rising edge of `ab_clk`, and the B-to-A register loads the B port input on each rising edge of `ba_clk`. An edge on one clock leaves the other register unchanged.
- R3: Capture takes place under every combination of `oe_n` and `dir`. This includes isolation, and it includes capturing the value that the block itself is driving onto a port.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are both all zeros, and `a_out` and `b_out` are both 8'h00.
- R5: While `oe_n` is 0 and `dir` is 1, `b_oe` is all ones and `a_oe` is all zeros.
- R6: While `oe_n` is 0 and `dir` is 0, `a_oe` is all ones and `b_oe` is all zeros.
- R7: When a port is driven and its select (`sel_ab` for B, `sel_ba` for A) is 0, its data output equals the opposite port's input bit for bit, with no inversion and no clock delay.
- R8: When a port is driven and its select is 1, its data output equals the stored register of that direction. A change of select takes effect with no clock edge.
- R9: The two ports are never driven together. Each output-enable vector is always all zeros or all ones, and a port whose enable is low has data output 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset of both registers |
| ab_clk | input | 1 | Rising-edge capture clock of the A-to-B register |
| ba_clk | input | 1 | Rising-edge capture clock of the B-to-A register |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 1 drives port B, 0 drives port A (when enabled) |
| sel_ab | input | 1 | Source for port B: 0 live A, 1 stored A-to-B register |
| sel_ba | input | 1 | Source for port A: 0 live B, 1 stored B-to-A register |
| a_in | input | 8 | Resolved value seen on port A |
| a_out | output | 8 | Data the block drives onto port A |
| a_oe | output | 8 | Per-bit drive enable for port A |
| b_in | input | 8 | Resolved value seen on port B |
| b_out | output | 8 | Data the block drives onto port B |
| b_oe | output | 8 | Per-bit drive enable for port B |

## Verification
The enable vectors and the live path are combinational. The bench changes a control or an input away from any capture edge and samples the ports one nanosecond later, in the same cycle. A stored value becomes visible only after the rising edge of its own capture clock. The bench completes each clock pulse and then reads the register through the driven port with its select high. A stored value therefore counts as due one capture edge after the stimulus, and a select change makes it visible at once. A tri-state model of both buses flags any cycle in which the block and the bench drive the same port.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;

  typedef enum logic [1:0] {
    XM_ISOLATE = 2'd0,
    XM_DRIVE_A = 2'd1,
    XM_DRIVE_B = 2'd2
  } xfer_mode_e;

  function automatic xfer_mode_e decode_mode(input logic oe_n, input logic dir);
    if (oe_n)
      return XM_ISOLATE;
    else if (dir)
      return XM_DRIVE_B;
    else
      return XM_DRIVE_A;
  endfunction

endpackage

// File: rtl/regxcvr_cap_reg.sv
module regxcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1: reset forces the register to zero
  always_comb begin
    if (rst_n == 1'b0) begin
      assert_reset_clear_R1: assert (q == '0);
    end
  end

  // R2: each edge of this register's own clock stores the port value
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/regxcvr_drive_ctl.sv
module regxcvr_drive_ctl
  import regxcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         oe_n,
  input  logic         dir,
  output logic         drv_a,
  output logic         drv_b,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_oe
);

  xfer_mode_e mode;

  always_comb begin
    mode  = decode_mode(oe_n, dir);
    drv_a = (mode == XM_DRIVE_A);
    drv_b = (mode == XM_DRIVE_B);
  end

  assign a_oe = {W{drv_a}};
  assign b_oe = {W{drv_b}};

  always_comb begin
    assert_one_port_R9: assert (!(a_oe[0] && b_oe[0]));
    if (oe_n == 1'b1) begin
      assert_isolate_R4: assert ((a_oe == '0) && (b_oe == '0));
    end
  end

endmodule

// File: rtl/regxcvr_src_mux.sv
module regxcvr_src_mux #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         sel_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out
);

  always_comb begin
    if (!en)             out = '0;
    else if (sel_stored) out = stored;
    else                 out = live;
  end

endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         ab_clk,
  input  logic         ba_clk,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;
  logic         drv_a;
  logic         drv_b;

  regxcvr_cap_reg #(.W(W)) u_ab_reg (
    .clk   (ab_clk),
    .rst_n (rst_n),
    .d     (a_in),
    .q     (ab_q)
  );

  regxcvr_cap_reg #(.W(W)) u_ba_reg (
    .clk   (ba_clk),
    .rst_n (rst_n),
    .d     (b_in),
    .q     (ba_q)
  );

  regxcvr_drive_ctl #(.W(W)) u_ctl (
    .oe_n  (oe_n),
    .dir   (dir),
    .drv_a (drv_a),
    .drv_b (drv_b),
    .a_oe  (a_oe),
    .b_oe  (b_oe)
  );

  regxcvr_src_mux #(.W(W)) u_mux_b (
    .en         (drv_b),
    .sel_stored (sel_ab),
    .live       (a_in),
    .stored     (ab_q),
    .out        (b_out)
  );

  regxcvr_src_mux #(.W(W)) u_mux_a (
    .en         (drv_a),
    .sel_stored (sel_ba),
    .live       (b_in),
    .stored     (ba_q),
    .out        (a_out)
  );

  // R9: an undriven port keeps its data output quiet
  always_comb begin
    if (a_oe[0] == 1'b0) begin
      assert_a_quiet_R9: assert (a_out == '0);
    end
    if (b_oe[0] == 1'b0) begin
      assert_b_quiet_R9: assert (b_out == '0);
    end
  end

endmodule

// File: tb/regxcvr_top_tb_top.sv
`timescale 1ns/1ps
module regxcvr_top_tb_top;

  logic       tb_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ab_clk = 1'b0;
  logic       ba_clk = 1'b0;
  logic       oe_n = 1'b1;
  logic       dir = 1'b0;
  logic       sel_ab = 1'b0;
  logic       sel_ba = 1'b0;
  logic [7:0] a_out, a_oe, b_out, b_oe;
  logic [7:0] a_bus, b_bus;
  logic       ext_a_en = 1'b0;
  logic       ext_b_en = 1'b0;
  logic [7:0] ext_a = 8'h00;
  logic [7:0] ext_b = 8'h00;

  int compared = 0;
  int mismatched = 0;
  int contention = 0;
  int wd_cnt = 0;
  bit done = 0;

  always #10 tb_clk = ~tb_clk;

  // bus model: block drives when enabled, otherwise the bench source (or 0)
  assign a_bus = a_oe[0] ? a_out : (ext_a_en ? ext_a : 8'h00);
  assign b_bus = b_oe[0] ? b_out : (ext_b_en ? ext_b : 8'h00);

  regxcvr_top dut_i (
    .rst_n (rst_n), .ab_clk (ab_clk), .ba_clk (ba_clk),
    .oe_n (oe_n), .dir (dir), .sel_ab (sel_ab), .sel_ba (sel_ba),
    .a_in (a_bus), .a_out (a_out), .a_oe (a_oe),
    .b_in (b_bus), .b_out (b_out), .b_oe (b_oe)
  );

  always @(posedge tb_clk) begin
    if ((a_oe != 8'h00 && ext_a_en) || (b_oe != 8'h00 && ext_b_en))
      contention++;
    if ((a_oe != 8'h00) && (b_oe != 8'h00))
      contention++;
  end

  always @(posedge tb_clk) begin
    wd_cnt++;
    if (wd_cnt > 100000 && !done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    @(negedge tb_clk); ab_clk = 1'b1;
    @(posedge tb_clk); ab_clk = 1'b0;
    #1;
  endtask

  task automatic pulse_ba();
    @(negedge tb_clk); ba_clk = 1'b1;
    @(posedge tb_clk); ba_clk = 1'b0;
    #1;
  endtask

  task automatic set_mode(input logic o, input logic d, input logic sab, input logic sba);
    @(negedge tb_clk);
    ext_a_en = 1'b0; ext_b_en = 1'b0;
    #1;
    oe_n = o; dir = d; sel_ab = sab; sel_ba = sba;
    #1;
    ext_a_en = !((o == 1'b0) && (d == 1'b0));
    ext_b_en = !((o == 1'b0) && (d == 1'b1));
    #1;
  endtask

  task automatic t_reset();
    set_mode(1'b0, 1'b1, 1'b1, 1'b0);
    check("R1 stored A-to-B after reset", b_out, 8'h00);
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    check("R1 stored B-to-A after reset", a_out, 8'h00);
  endtask

  task automatic t_isolation_capture();
    set_mode(1'b1, 1'b0, 1'b1, 1'b1);
    ext_a = 8'hA5; ext_b = 8'h5A; #1;
    check("R4 a_oe isolated", a_oe, 8'h00);
    check("R4 b_oe isolated", b_oe, 8'h00);
    check("R4 a_out quiet", a_out, 8'h00);
    check("R4 b_out quiet", b_out, 8'h00);
    pulse_ab();
    pulse_ba();
    set_mode(1'b0, 1'b1, 1'b1, 1'b1);
    check("R3 isolated capture A-to-B", b_out, 8'hA5);
    set_mode(1'b0, 1'b0, 1'b1, 1'b1);
    check("R3 isolated capture B-to-A", a_out, 8'h5A);
  endtask

  task automatic t_b_from_a_live();
    set_mode(1'b0, 1'b1, 1'b0, 1'b0);
    check("R5 b_oe on", b_oe, 8'hFF);
    check("R5 a_oe off", a_oe, 8'h00);
    ext_a = 8'h81; #1;
    check("R7 live A to B 81", b_out, 8'h81);
    ext_a = 8'h7E; #1;
    check("R7 live A to B 7E no inversion", b_out, 8'h7E);
  endtask

  task automatic t_b_from_a_stored();
    set_mode(1'b0, 1'b1, 1'b0, 1'b0);
    ext_a = 8'h3C; #1;
    pulse_ab();
    ext_a = 8'hC3; #1;
    check("R7 live before select", b_out, 8'hC3);
    sel_ab = 1'b1; #1;
    check("R8 stored A to B same cycle", b_out, 8'h3C);
    ext_a = 8'h11; #1;
    check("R8 stored ignores live A", b_out, 8'h3C);
  endtask

  task automatic t_a_from_b();
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 a_oe on", a_oe, 8'hFF);
    check("R6 b_oe off", b_oe, 8'h00);
    ext_b = 8'h96; #1;
    check("R7 live B to A", a_out, 8'h96);
    pulse_ba();
    ext_b = 8'h00; #1;
    sel_ba = 1'b1; #1;
    check("R8 stored B to A", a_out, 8'h96);
  endtask

  task automatic t_capture_while_driving();
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    ext_b = 8'h4D; #1;
    pulse_ab();
    set_mode(1'b0, 1'b1, 1'b1, 1'b0);
    check("R3 captured driven A port", b_out, 8'h4D);
  endtask

  task automatic t_clock_independence();
    set_mode(1'b1, 1'b0, 1'b0, 1'b0);
    ext_a = 8'hE1; ext_b = 8'h1E; #1;
    pulse_ab();
    pulse_ba();
    ext_a = 8'h22; ext_b = 8'h44; #1;
    pulse_ab();
    set_mode(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 B-to-A untouched by ab_clk", a_out, 8'h1E);
    ext_b = 8'h55; #1;
    pulse_ba();
    set_mode(1'b0, 1'b1, 1'b1, 1'b0);
    check("R2 A-to-B untouched by ba_clk", b_out, 8'h22);
  endtask

  initial begin
    #35;
    rst_n = 1'b1;
    #5;
    t_reset();
    t_isolation_capture();
    t_b_from_a_live();
    t_b_from_a_stored();
    t_a_from_b();
    t_capture_while_driving();
    t_clock_independence();
    compared++;
    if (contention != 0) begin
      mismatched++;
      $display("FAIL R9 bus contention: actual %0d expected 0", contention);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule